// File: doc/BRIEF.md
# Transition-Based Loss of Signal Detector

This block watches a recovered NRZ bit stream, one bit per unit interval (UI), and flags loss of signal when the line stops toggling. A bit is presented with a one-cycle valid strobe. A transition is a change of value between two consecutive valid bits. When the line has gone a full idle window (a parameter in UI, about 2.3 microseconds of line time) without a single transition, the flag rises. The flag drops again only when the recent activity is dense enough: more than a set number of transitions among the most recent valid bits of a short sliding window. Setting and clearing therefore use different conditions.

While the flag is up, the receive data output is forced to zero. The clock output is a plain copy of the input clock and keeps running whatever the flag does. Detection is switched off while the receiver runs in local loopback or in monitor mode. In those modes the flag is held low and the idle measurement restarts. The flag comes out of reset set, so no data is passed until the line has shown real activity.

Top module: `los_detector`

## Requirements
- R1: When IDLE_UI consecutive valid bits arrive with no transition between them, losFlag goes high at the clock edge that follows the one taking the IDLE_UI-th such bit.
- R2: Once set, losFlag goes low at the edge after the most recent WIN_UI valid bits hold more than CLR_MIN transitions (default window 32, threshold 4). Exactly CLR_MIN transitions in the window leave the flag set.
- R3: While losFlag is high, dataOut is 0 whatever dataIn is.
- R4: While losFlag is low, dataOut equals dataIn in the same cycle.
- R5: While loopbackEn or monitorEn is high, losFlag is low from the next edge on, and the idle count is held at zero. After both modes drop, the flag can rise again only after a fresh run of IDLE_UI valid bits without a transition.
- R6: clkOut follows clk at all times, including while losFlag is high.
- R7: During and straight after reset, losFlag is high and dataOut is 0.
- R8: Cycles with bitValid low are ignored: they neither count as idle UI nor create a transition, whatever dataIn does. The first valid bit after reset is compared with nothing.
- R9: Every transition restarts the idle count. A run of IDLE_UI equal bits that starts with a transition (IDLE_UI-1 idle UI after it) does not set the flag. The count saturates at IDLE_UI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered UI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | High when dataIn carries a new bit |
| dataIn | input | 1 | Recovered NRZ data bit |
| loopbackEn | input | 1 | Local loopback active; disables detection |
| monitorEn | input | 1 | Receive monitor mode active; disables detection |
| clkOut | output | 1 | Receive clock, a free-running copy of clk |
| losFlag | output | 1 | Loss-of-signal flag, active high |
| dataOut | output | 1 | Receive data, forced to 0 while losFlag is high |

## Verification
The bench builds the detector with IDLE_UI set to 40, and keeps the 32-bit window and the threshold of 4. With this setting the idle boundary shows up after a few dozen bits. Run lengths of exactly 40 and 41 equal bits then test the off-by-one edge of the set condition in both directions. Keeping the default window lets transitions spaced 8 apart hold the flag at exactly the threshold, while spacing them 6 apart clears it. A short idle window also lets the loopback, monitor and gapped-valid cases each run into a fresh assertion within a short run.

// File: rtl/los_pkg.sv
package los_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;   // a valid bit is on dataIn this cycle
    logic restart;   // detection disabled: hold idle measurement at zero
  } losStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic idleExpired;  // idle count has reached its threshold
    logic activityOk;   // window transition count above threshold
  } losStatus_t;

endpackage

// File: rtl/los_datapath.sv
module los_datapath
  import los_pkg::*;
#(
  parameter int IDLE_UI = 358,
  parameter int WIN_UI  = 32,
  parameter int CLR_MIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  losStrobe_t strobe,
  input  logic       dataIn,
  output losStatus_t status
);

  localparam int IDLE_W = $clog2(IDLE_UI + 1);
  localparam int POP_W  = $clog2(WIN_UI + 1);

  logic              prevBit;
  logic              havePrev;
  logic              transNow;
  logic [IDLE_W-1:0] idleCnt;
  logic [WIN_UI-1:0] transHist;
  logic [POP_W-1:0]  popCnt;

  assign transNow = strobe.advance && havePrev && (dataIn != prevBit);

  // last-bit memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevBit  <= 1'b0;
      havePrev <= 1'b0;
    end else if (strobe.advance) begin
      prevBit  <= dataIn;
      havePrev <= 1'b1;
    end
  end

  // saturating idle-UI counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (strobe.restart) begin
      idleCnt <= '0;
    end else if (strobe.advance) begin
      if (transNow)
        idleCnt <= '0;
      else if (!status.idleExpired)
        idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

  // sliding window of transition flags
  generate
    if (WIN_UI > 1) begin : g_hist_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          transHist <= '0;
        else if (strobe.advance)
          transHist <= {transHist[WIN_UI-2:0], transNow};
      end
    end else begin : g_hist_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          transHist <= '0;
        else if (strobe.advance)
          transHist <= transNow;
      end
    end
  endgenerate

  // population count over the window
  always_comb begin
    popCnt = '0;
    for (int i = 0; i < WIN_UI; i++)
      popCnt = popCnt + POP_W'(transHist[i]);
  end

  assign status.idleExpired = (idleCnt >= IDLE_W'(IDLE_UI));
  assign status.activityOk  = (popCnt > POP_W'(CLR_MIN));

endmodule

// File: rtl/los_control.sv
module los_control
  import los_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bitValid,
  input  logic       loopbackEn,
  input  logic       monitorEn,
  input  losStatus_t status,
  output losStrobe_t strobe,
  output logic       losFlag
);

  typedef enum logic {ST_LOST = 1'b1, ST_LIVE = 1'b0} losState_e;

  losState_e state, stateNext;
  logic      gateOff;

  assign gateOff        = loopbackEn || monitorEn;
  assign strobe.advance = bitValid;
  assign strobe.restart = gateOff;

  always_comb begin
    stateNext = state;
    if (gateOff)
      stateNext = ST_LIVE;
    else if (state == ST_LOST && status.activityOk)
      stateNext = ST_LIVE;
    else if (state == ST_LIVE && status.idleExpired)
      stateNext = ST_LOST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOST;
    else        state <= stateNext;
  end

  assign losFlag = (state == ST_LOST);

endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int IDLE_UI = 358,
  parameter int WIN_UI  = 32,
  parameter int CLR_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bitValid,
  input  logic dataIn,
  input  logic loopbackEn,
  input  logic monitorEn,
  output logic clkOut,
  output logic losFlag,
  output logic dataOut
);

  losStrobe_t strobe;
  losStatus_t status;

  los_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bitValid   (bitValid),
    .loopbackEn (loopbackEn),
    .monitorEn  (monitorEn),
    .status     (status),
    .strobe     (strobe),
    .losFlag    (losFlag)
  );

  los_datapath #(
    .IDLE_UI (IDLE_UI),
    .WIN_UI  (WIN_UI),
    .CLR_MIN (CLR_MIN)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .dataIn (dataIn),
    .status (status)
  );

  assign clkOut  = clk;
  assign dataOut = dataIn && !losFlag;

endmodule

// File: rtl/los_checks.sv
module los_checks #(
  parameter int IDLE_UI = 358,
  parameter int WIN_UI  = 32,
  parameter int CLR_MIN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic bitValid,
  input logic dataIn,
  input logic loopbackEn,
  input logic monitorEn,
  input logic clkOut,
  input logic losFlag,
  input logic dataOut
);

  localparam int IDLE_W = $clog2(IDLE_UI + 1);
  localparam int POP_W  = $clog2(WIN_UI + 1);

  logic              gateIn;
  logic              lastBit;
  logic              seenBit;
  logic              edgeSeen;
  logic [IDLE_W-1:0] runCnt;
  logic [WIN_UI-1:0] winFlags;
  logic [POP_W-1:0]  winPop;

  assign gateIn   = loopbackEn || monitorEn;
  assign edgeSeen = bitValid && seenBit && (dataIn != lastBit);
  assign winPop   = POP_W'($countones(winFlags));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastBit  <= 1'b0;
      seenBit  <= 1'b0;
      runCnt   <= '0;
      winFlags <= '0;
    end else begin
      if (bitValid) begin
        lastBit  <= dataIn;
        seenBit  <= 1'b1;
        winFlags <= (winFlags << 1) | WIN_UI'(edgeSeen);
      end
      if (gateIn || edgeSeen)
        runCnt <= '0;
      else if (bitValid && runCnt < IDLE_W'(IDLE_UI))
        runCnt <= runCnt + IDLE_W'(1);
    end
  end

  // R1: a rising flag needs a full idle run before the edge that set it
  p_set_after_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(losFlag) |-> $past(runCnt) >= IDLE_W'(IDLE_UI));

  // R2: a falling flag outside the disabled modes needs dense activity
  p_clear_on_activity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(losFlag) && !$past(gateIn)) |-> $past(winPop) > POP_W'(CLR_MIN));

  // R3: squelch while lost
  p_squelch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    losFlag |-> !dataOut);

  // R4: transparent while live
  p_pass_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !losFlag |-> (dataOut == dataIn));

  // R5: disabled modes hold the flag low
  p_mode_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gateIn |=> !losFlag);

  // R6: clock output tracks clock input
  always_comb begin
    p_clock_follow_r6: assert (clkOut == clk);
  end

endmodule

bind los_detector los_checks #(
  .IDLE_UI (IDLE_UI),
  .WIN_UI  (WIN_UI),
  .CLR_MIN (CLR_MIN)
) u_los_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .bitValid   (bitValid),
  .dataIn     (dataIn),
  .loopbackEn (loopbackEn),
  .monitorEn  (monitorEn),
  .clkOut     (clkOut),
  .losFlag    (losFlag),
  .dataOut    (dataOut)
);

// File: tb/los_detector_tb.sv
module los_detector_tb;

  localparam int IDLE_UI = 40;
  localparam int WIN_UI  = 32;
  localparam int CLR_MIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bitValid = 1'b0;
  logic dataIn = 1'b0;
  logic loopbackEn = 1'b0;
  logic monitorEn = 1'b0;
  logic clkOut, losFlag, dataOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  los_detector #(
    .IDLE_UI (IDLE_UI),
    .WIN_UI  (WIN_UI),
    .CLR_MIN (CLR_MIN)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bitValid   (bitValid),
    .dataIn     (dataIn),
    .loopbackEn (loopbackEn),
    .monitorEn  (monitorEn),
    .clkOut     (clkOut),
    .losFlag    (losFlag),
    .dataOut    (dataOut)
  );

  typedef struct {
    logic  expLos;
    logic  expData;
    string tag;
  } item_t;

  item_t expQ[$];

  // reference model state (post-edge view)
  logic        mLos;
  logic        mPrev;
  logic        mHave;
  int          mIdle;
  logic [31:0] mHist;

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push expectation, advance model
  task automatic drive(input logic v, input logic d, input logic lb, input logic mon, input string tag);
    item_t it;
    logic gate, trans, nextLos;
    @(negedge clk);
    bitValid = v; dataIn = d; loopbackEn = lb; monitorEn = mon;
    it.expLos = mLos;
    it.expData = d & ~mLos;
    it.tag = tag;
    expQ.push_back(it);
    gate = lb | mon;
    if (gate) nextLos = 1'b0;
    else if (mLos) nextLos = !($countones(mHist) > CLR_MIN);
    else nextLos = (mIdle >= IDLE_UI);
    trans = v && mHave && (d != mPrev);
    if (v) begin
      mHist = {mHist[30:0], trans};
      mPrev = d;
      mHave = 1'b1;
    end
    if (gate) mIdle = 0;
    else if (v) begin
      if (trans) mIdle = 0;
      else if (mIdle < IDLE_UI) mIdle++;
    end
    mLos = nextLos;
  endtask

  task automatic holdRun(input int n, input logic d, input string tag);
    for (int i = 0; i < n; i++) drive(1'b1, d, 1'b0, 1'b0, tag);
  endtask

  task automatic toggleRun(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b1, ~mPrev, 1'b0, 1'b0, tag);
  endtask

  // one transition every 'gap' bits
  task automatic sparseRun(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++)
      drive(1'b1, (i % gap == 0) ? ~mPrev : mPrev, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare as the design produces results
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        check(it.tag, losFlag, it.expLos, "losFlag");
        check(it.tag, dataOut, it.expData, "dataOut");
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mLos = 1'b1; mPrev = 1'b0; mHave = 1'b0; mIdle = 0; mHist = '0;

    // R7: reset state, data squelched
    dataIn = 1'b1; bitValid = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R7", losFlag, 1'b1, "losFlag in reset");
    check("R7", dataOut, 1'b0, "dataOut in reset");
    @(negedge clk);
    rst_n = 1'b1; bitValid = 1'b0; dataIn = 1'b0;
    #2;
    check("R7", losFlag, 1'b1, "losFlag after reset");

    // R6: clock passes through
    @(posedge clk); #1;
    check("R6", clkOut, 1'b1, "clkOut high");
    @(negedge clk); #1;
    check("R6", clkOut, 1'b0, "clkOut low");

    // R2/R4: alternating data clears, then data passes
    toggleRun(12, "R2");
    toggleRun(10, "R4");

    // R9: run of IDLE_UI equal bits does not set, repeated
    holdRun(IDLE_UI, ~mPrev, "R9");
    holdRun(IDLE_UI, ~mPrev, "R9");
    // R1: one more bit sets the flag
    holdRun(IDLE_UI + 1, ~mPrev, "R1");
    holdRun(4, mPrev, "R1");
    // R3: squelch with ones on the line
    holdRun(6, 1'b1, "R3");

    // R2 boundary: four transitions per window keeps the flag
    sparseRun(96, 8, "R2");
    // R2: six-bit spacing clears
    sparseRun(40, 6, "R2");
    toggleRun(8, "R4");

    // R8: invalid cycles with toggling data do not count as transitions
    for (int i = 0; i < IDLE_UI + 6; i++) begin
      drive(1'b1, mPrev, 1'b0, 1'b0, "R8");
      drive(1'b0, ~mPrev, 1'b0, 1'b0, "R8");
    end

    // R5: loopback clears and holds flag low on an idle line
    toggleRun(4, "R5");
    for (int i = 0; i < IDLE_UI + 20; i++) drive(1'b1, mPrev, 1'b1, 1'b0, "R5");
    // R5: after leaving loopback a fresh idle run is needed
    holdRun(IDLE_UI + 3, mPrev, "R5");
    // R5: monitor mode clears an asserted flag
    for (int i = 0; i < 10; i++) drive(1'b1, mPrev, 1'b0, 1'b1, "R5");
    holdRun(IDLE_UI + 3, mPrev, "R5");

    drive(1'b0, 1'b0, 1'b0, 1'b0, "R3");
    repeat (3) @(negedge clk);
    #4;
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", expQ.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule